// File: doc/BRIEF.md
# Signed Logarithmic Arithmetic Unit

This unit does arithmetic on values held as a sign and a base-2 logarithm instead of as a mantissa. Each operand is one sign bit above a biased fixed-point log field. The field has K_BITS integer bits and F_BITS fraction bits. A product or a quotient needs only one add or subtract of the log fields, a bias correction and an XOR of the signs. A sum of two operands with the same sign takes the larger log field and adds a correction term, log2(1 + 2^-d). That term comes from a small constant table indexed by the log difference d.

A request is one operand pair with an opcode, qualified by a valid strobe. The result and its flags appear one clock later. Results that leave the field range saturate or clamp and raise a flag. An add of opposite-sign operands, and the reserved opcode, raise an unsupported flag instead of producing a result.

Top module: `lns_arith_unit`

## Requirements
- R1: An operand or result of N = 1 + K_BITS + F_BITS bits holds the sign in bit N-1 (0 positive, 1 negative) and an unsigned log field in bits N-2:0. With the defaults (K_BITS=4, F_BITS=4) the value is (-1)^sign * 2^(field/16 - 7), so the field value 112 means magnitude 1.0.
- R2: valid_o equals valid_i as sampled at the previous rising clock edge.
- R3: Opcode 2'b00 multiplies. The result field is field_a + field_b - 112 and the result sign is sign_a XOR sign_b.
- R4: Opcode 2'b01 divides a by b. The result field is field_a - field_b + 112 and the result sign is sign_a XOR sign_b.
- R5: Opcode 2'b10 with equal signs adds. Let hi be the larger field and d = hi - lo. The result field is hi + c and the sign is the common sign. c is round(16 * log2(1 + 2^-q)), where q is d truncated to a multiple of 0.25 (d/16 rounded down to quarter steps). c is 0 when d >= 128, which is a difference of 8.0.
- R6: A raw result field above 255 raises ovf_o and the field saturates to 255. A result of exactly 255 raises no flag.
- R7: A raw result field below 0 raises unf_o and the field clamps to 0.
- R8: Opcode 2'b10 with different signs, and opcode 2'b11, raise unsup_o and hold ovf_o and unf_o low. At most one of the three flags is high at a time.
- R9: While rst_ni is low, valid_o, res_o, ovf_o, unf_o and unsup_o are all 0.
- R10: In a cycle where valid_o is low, all three flags are low and res_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Opcode: 00 multiply, 01 divide, 10 add, 11 reserved |
| a_i | input | N | First operand |
| b_i | input | N | Second operand (divisor for divide) |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| res_o | output | N | Result in operand format |
| ovf_o | output | 1 | Result saturated high |
| unf_o | output | 1 | Result clamped to zero |
| unsup_o | output | 1 | Request not supported; res_o undefined |

## Verification
The checker holds some properties on every cycle:
- the one-cycle strobe delay;
- the exclusive flags;
- quiet flags and a held result while idle;
- the saturation and clamp values whenever a flag is set;
- the XOR sign of products;
- a sum field never smaller than the larger input field.

Only the bench's scenarios can show the exact arithmetic values. These are the bias arithmetic of multiply and divide, the correction value picked for each difference, the table cut-off at a difference of 8.0, and the points where each path overflows, underflows or sits exactly on the 255 boundary.

// File: rtl/lns_arith_pkg.sv
package lns_arith_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_DIV = 2'b01,
    OP_ADD = 2'b10,
    OP_RSV = 2'b11
  } lns_op_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic unsup;
  } lns_flags_t;

endpackage

// File: rtl/lns_corr_rom.sv
// Correction term log2(1+2^-d), indexed by d in quarter steps over [0, 8).
module lns_corr_rom #(
  parameter int F_BITS = 4,
  parameter int W      = 8
) (
  input  logic [W-1:0] diff_i,
  output logic [W-1:0] corr_o
);
  localparam int TBL_INT  = 3;
  localparam int TBL_FRAC = 2;
  localparam int IDX_W    = TBL_INT + TBL_FRAC;
  localparam int TOP_BIT  = F_BITS + TBL_INT;
  localparam int LO_BIT   = F_BITS - TBL_FRAC;

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [4:0]       base;
  logic [W-1:0]     base_w;

  assign in_range = (diff_i >> TOP_BIT) == '0;
  assign idx      = diff_i[TOP_BIT-1:LO_BIT];

  // entries in units of 1/16
  always_comb begin
    unique case (idx)
      5'd0:  base = 5'd16;
      5'd1:  base = 5'd14;
      5'd2:  base = 5'd12;
      5'd3:  base = 5'd11;
      5'd4:  base = 5'd9;
      5'd5:  base = 5'd8;
      5'd6:  base = 5'd7;
      5'd7:  base = 5'd6;
      5'd8:  base = 5'd5;
      5'd9:  base = 5'd4;
      5'd10: base = 5'd4;
      5'd11: base = 5'd3;
      5'd12: base = 5'd3;
      5'd13: base = 5'd2;
      5'd14: base = 5'd2;
      5'd15: base = 5'd2;
      5'd16, 5'd17, 5'd18, 5'd19,
      5'd20, 5'd21, 5'd22: base = 5'd1;
      default: base = 5'd0;
    endcase
  end

  assign base_w = W'(base);

  generate
    if (F_BITS >= 4) begin : g_scale_up
      assign corr_o = in_range ? (base_w << (F_BITS - 4)) : '0;
    end else begin : g_scale_dn
      assign corr_o = in_range ? (base_w >> (4 - F_BITS)) : '0;
    end
  endgenerate

endmodule

// File: rtl/lns_sat.sv
module lns_sat #(
  parameter int W = 8
) (
  input  logic signed [W+1:0] raw_i,
  output logic [W-1:0]        field_o,
  output logic                ovf_o,
  output logic                unf_o
);
  localparam logic signed [W+1:0] MAX_X = (W+2)'((2 ** W) - 1);

  always_comb begin
    ovf_o   = 1'b0;
    unf_o   = 1'b0;
    field_o = raw_i[W-1:0];
    if (raw_i < 0) begin
      unf_o   = 1'b1;
      field_o = '0;
    end else if (raw_i > MAX_X) begin
      ovf_o   = 1'b1;
      field_o = '1;
    end
  end

endmodule

// File: rtl/lns_mul_div.sv
module lns_mul_div #(
  parameter int K_BITS = 4,
  parameter int F_BITS = 4,
  parameter int W      = K_BITS + F_BITS
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic                div_i,
  output logic signed [W+1:0] raw_o
);
  localparam int EXT_W   = W + 2;
  localparam int BIAS_SC = ((2 ** (K_BITS - 1)) - 1) * (2 ** F_BITS);
  localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS_SC);

  logic signed [EXT_W-1:0] a_x, b_x;

  assign a_x   = {2'b00, a_i};
  assign b_x   = {2'b00, b_i};
  assign raw_o = div_i ? (a_x - b_x + BIAS_X) : (a_x + b_x - BIAS_X);

endmodule

// File: rtl/lns_add.sv
module lns_add #(
  parameter int F_BITS = 4,
  parameter int W      = 8
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  output logic signed [W+1:0] raw_o
);
  logic [W-1:0] hi, lo, diff, corr;

  assign hi   = (a_i >= b_i) ? a_i : b_i;
  assign lo   = (a_i >= b_i) ? b_i : a_i;
  assign diff = hi - lo;

  lns_corr_rom #(
    .F_BITS (F_BITS),
    .W      (W)
  ) u_rom (
    .diff_i (diff),
    .corr_o (corr)
  );

  assign raw_o = $signed({2'b00, hi}) + $signed({2'b00, corr});

endmodule

// File: rtl/lns_arith_unit.sv
module lns_arith_unit
  import lns_arith_pkg::*;
#(
  parameter int K_BITS = 4,
  parameter int F_BITS = 4,
  localparam int W     = K_BITS + F_BITS,
  localparam int N     = W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         valid_o,
  output logic [N-1:0] res_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         unsup_o
);
  lns_op_e            op;
  logic               sa, sb;
  logic [W-1:0]       fa, fb;
  logic signed [W+1:0] raw_md, raw_add, raw_sel;
  logic [W-1:0]       field;
  logic               s_ovf, s_unf;
  logic               res_sign;
  lns_flags_t         flags_d, flags_q;

  assign op = lns_op_e'(op_i);
  assign sa = a_i[N-1];
  assign sb = b_i[N-1];
  assign fa = a_i[W-1:0];
  assign fb = b_i[W-1:0];

  lns_mul_div #(
    .K_BITS (K_BITS),
    .F_BITS (F_BITS),
    .W      (W)
  ) u_md (
    .a_i   (fa),
    .b_i   (fb),
    .div_i (op == OP_DIV),
    .raw_o (raw_md)
  );

  lns_add #(
    .F_BITS (F_BITS),
    .W      (W)
  ) u_add (
    .a_i   (fa),
    .b_i   (fb),
    .raw_o (raw_add)
  );

  assign raw_sel = (op == OP_ADD) ? raw_add : raw_md;

  lns_sat #(.W(W)) u_sat (
    .raw_i   (raw_sel),
    .field_o (field),
    .ovf_o   (s_ovf),
    .unf_o   (s_unf)
  );

  always_comb begin
    flags_d  = '0;
    res_sign = sa ^ sb;
    unique case (op)
      OP_ADD: begin
        res_sign      = sa;
        flags_d.unsup = sa ^ sb;
      end
      OP_RSV:  flags_d.unsup = 1'b1;
      default: ;
    endcase
    if (!flags_d.unsup) begin
      flags_d.ovf = s_ovf;
      flags_d.unf = s_unf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flags_q <= '0;
    end else begin
      valid_o <= valid_i;
      flags_q <= valid_i ? flags_d : '0;
      if (valid_i) res_o <= {res_sign, field};
    end
  end

  assign ovf_o   = flags_q.ovf;
  assign unf_o   = flags_q.unf;
  assign unsup_o = flags_q.unsup;

endmodule

// File: rtl/lns_arith_unit_chk.sv
module lns_arith_unit_chk #(
  parameter int K_BITS = 4,
  parameter int F_BITS = 4,
  localparam int W     = K_BITS + F_BITS,
  localparam int N     = W + 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   op_i,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         valid_o,
  input logic [N-1:0] res_o,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         unsup_o
);
  logic         past_ok;
  logic [W-1:0] hi_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign hi_in = (a_i[W-1:0] >= b_i[W-1:0]) ? a_i[W-1:0] : b_i[W-1:0];

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i))); // R2

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ovf_o, unf_o, unsup_o}) <= 1); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(ovf_o || unf_o || unsup_o)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !valid_o) |-> $stable(res_o)); // R10

  AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (res_o[W-1:0] == '1)); // R6

  AST_UNF_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && unf_o) |-> (res_o[W-1:0] == '0)); // R7

  AST_MUL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && op_i == 2'b00))
      |-> (res_o[N-1] == $past(a_i[N-1] ^ b_i[N-1]))); // R3

  AST_ADD_NOT_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && op_i == 2'b10 && a_i[N-1] == b_i[N-1]))
      |-> (res_o[W-1:0] >= $past(hi_in))); // R5

endmodule

bind lns_arith_unit lns_arith_unit_chk #(
  .K_BITS (K_BITS),
  .F_BITS (F_BITS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o),
  .unsup_o (unsup_o)
);

// File: tb/lns_arith_unit_test.sv
`timescale 1ns/1ps
module lns_arith_unit_test;
  localparam int N = 9;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic         valid_o, ovf_o, unf_o, unsup_o;
  logic [N-1:0] res_o;

  int n_chk = 0;
  int n_fail = 0;
  int last_res = 0;

  always #2 clk_i = ~clk_i;

  lns_arith_unit uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i,
    .valid_o, .res_o, .ovf_o, .unf_o, .unsup_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int corr_f(input int d);
    real q, v;
    if (d >= 128) return 0;
    q = real'(d / 4) / 4.0;
    v = 16.0 * $ln(1.0 + 2.0 ** (-q)) / $ln(2.0);
    return $rtoi(v + 0.5);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(input int op, input int a, input int b);
    int fa, fb, sa, sb, raw, sgn, uns, ovf, unf, fld, hi, lo;
    string tag;
    fa = a & 255; fb = b & 255; sa = (a >> 8) & 1; sb = (b >> 8) & 1;
    uns = 0; raw = 0; sgn = sa ^ sb; tag = "R3";
    case (op)
      0: raw = fa + fb - 112;
      1: begin raw = fa - fb + 112; tag = "R4"; end
      2: begin
        tag = "R5"; sgn = sa;
        if (sa != sb) uns = 1;
        hi = (fa >= fb) ? fa : fb;
        lo = (fa >= fb) ? fb : fa;
        raw = hi + corr_f(hi - lo);
      end
      default: uns = 1;
    endcase
    ovf = (!uns && raw > 255) ? 1 : 0;
    unf = (!uns && raw < 0) ? 1 : 0;
    fld = raw > 255 ? 255 : (raw < 0 ? 0 : raw);
    valid_i = 1'b1; op_i = 2'(op); a_i = N'(a); b_i = N'(b);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 valid", int'(valid_o), 1);
    check("R8 unsup", int'(unsup_o), uns);
    if (!uns) begin
      check({tag, " field"}, int'(res_o[7:0]), fld);
      check({tag, " sign"}, int'(res_o[8]), sgn);
      check("R6 ovf", int'(ovf_o), ovf);
      check("R7 unf", int'(unf_o), unf);
    end else begin
      check("R8 ovf low", int'(ovf_o), 0);
      check("R8 unf low", int'(unf_o), 0);
    end
    last_res = int'(res_o);
  endtask

  task automatic idle_cycle();
    valid_i = 1'b0;
    a_i = N'($urandom); b_i = N'($urandom);
    @(negedge clk_i);
    check("R2 idle valid", int'(valid_o), 0);
    check("R10 idle flags", int'({ovf_o, unf_o, unsup_o}), 0);
    check("R10 idle hold", int'(res_o), last_res);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd486));
    repeat (3) @(negedge clk_i);
    valid_i = 1'b1; a_i = 9'h1ff; b_i = 9'h1ff;
    @(negedge clk_i);
    check("R9 reset valid", int'(valid_o), 0);
    check("R9 reset res", int'(res_o), 0);
    check("R9 reset flags", int'({ovf_o, unf_o, unsup_o}), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: 2.0 * -0.5 = -1.0 -> sign 1, field 112
    run_op(0, 128, 256 + 96);
    check("R1 encoding", last_res, 256 + 112);
    run_op(0, 112, 112);          // R3 1*1
    run_op(0, 255, 255);          // R6
    run_op(0, 143, 224);          // R6 boundary, exactly 255
    run_op(0, 0, 0);              // R7
    run_op(0, 56, 56);            // R7 boundary, exactly 0
    run_op(1, 255, 0);            // R4 overflow
    run_op(1, 0, 255);            // R4 underflow
    run_op(1, 255, 112);          // R4 boundary
    run_op(1, 256 + 50, 70);      // R4 sign
    run_op(2, 112, 112);          // R5 d=0
    run_op(2, 200, 73);           // R5 d=127, last table slot
    run_op(2, 200, 72);           // R5 d=128, beyond table
    run_op(2, 188, 100);          // R5 d=5.5
    run_op(2, 256 + 90, 256 + 91);// R5 negative pair
    run_op(2, 255, 255);          // R6 on add
    run_op(2, 100, 256 + 100);    // R8 opposite signs
    run_op(3, 10, 20);            // R8 reserved opcode
    idle_cycle();                 // R10
    idle_cycle();

    for (int i = 0; i < 3000; i++) begin
      int op, a, b;
      op = int'($urandom % 4);
      a  = int'($urandom % 512);
      b  = int'($urandom % 512);
      if (op == 2 && ($urandom % 4) != 0) b = (b & 255) | (a & 256);
      run_op(op, a, b);
      if (($urandom % 8) == 0) idle_cycle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule